// File: doc/BRIEF.md
# Hot-Swap Channel Fault Sequencer

This block is the digital sequencer for one channel of a hot-swap power switch. It decides when the external pass transistor may be driven, when soft-start must be held in reset, and when a fault is reported. The inputs are already digitized and synchronous to the clock: a power-on-good flag, an active-low enable, a flag saying the load current sits at the regulation limit, a flag for a severe overcurrent, a soft-start-complete flag and a latch/retry mode select. The analog timing capacitor is replaced by a cycle counter whose length is a static input.

When the limit flag stays high for a full timeout, the channel is shut off and the fault output goes low. In latch mode the channel then stays off until enable is released and applied again. In retry mode it waits out 64 whole timeout intervals with the gate off, then clears the fault and starts a fresh soft-start. A severe overcurrent only produces a single-cycle pulldown strobe and leaves the gate enabled, so the limit timer decides whether the fault persists.

The caller reads a 3-bit state code for observation. All outputs come from flops.

Top module: `hs_fault_seq`

## Requirements
- R1: While `rst_ni` is low or `por_ok_i` is low, the block is in state OFF (code 0) one cycle later, with `gate_en_o`=0, `ss_rst_o`=1, `fault_no`=1, `gate_pd_o`=0, and the timer and the retry count cleared.
- R2: With `por_ok_i`=1, `en_ni`=0 moves OFF to SOFT (code 1) on the next clock, with `gate_en_o`=1 and `ss_rst_o`=0. `en_ni`=1 in any state returns the block to OFF on the next clock.
- R3: In SOFT with `lim_i`=0, `ss_done_i`=1 moves the block to ON (code 2). When TIMING (code 3) ends because `lim_i` falls, the block goes to ON if `ss_done_i`=1 and to SOFT otherwise.
- R4: In SOFT, ON or TIMING, a clock edge with `lim_i`=1 advances the overcurrent timer and enters TIMING. A clock with `lim_i`=0 clears the timer, so a burst shorter than the timeout causes no fault.
- R5: On the clock edge that samples `lim_i`=1 for the T-th consecutive time (T = effective timeout), `gate_pd_o` is 1 for exactly that one cycle, and `gate_en_o`=0, `ss_rst_o`=1, `fault_no`=0.
- R6: With `retry_i`=0, a timeout enters LATCHED (code 4). The block stays there with the fault asserted, whatever `lim_i` does, until `en_ni` goes high. The block then goes to OFF with `fault_no`=1.
- R7: With `retry_i`=1, a timeout enters RETRY_WAIT (code 5). The block stays there for exactly 64·T cycles with the gate off and the fault asserted. It then enters SOFT with `fault_no`=1.
- R8: If `lim_i` is still high after a retry, the timer runs again, and a timeout after T cycles repeats the fault and wait sequence.
- R9: In SOFT, ON or TIMING, a rising edge of `sev_oc_i` gives `gate_pd_o`=1 for one cycle while `gate_en_o` stays 1. In OFF, LATCHED and RETRY_WAIT, the input `sev_oc_i` has no effect.
- R10: A `tout_i` of 0 acts as a timeout of one cycle.
- R11: `en_ni` going high during RETRY_WAIT gives OFF with `fault_no`=1 and discards the retry count. A later fault then waits the full 64·T cycles.
- R12: `state_o` reports OFF=0, SOFT=1, ON=2, TIMING=3, LATCHED=4, RETRY_WAIT=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_ok_i | input | 1 | Supply above power-on threshold |
| en_ni | input | 1 | Channel enable, active low |
| lim_i | input | 1 | Load current at regulation limit |
| sev_oc_i | input | 1 | Severe overcurrent detected |
| retry_i | input | 1 | 1 = auto-retry, 0 = latch off |
| ss_done_i | input | 1 | Soft-start ramp finished |
| tout_i | input | TW | Timeout length in cycles (0 treated as 1) |
| gate_en_o | output | 1 | Gate drive enable |
| gate_pd_o | output | 1 | One-cycle fast gate pulldown strobe |
| ss_rst_o | output | 1 | Hold soft-start in reset |
| fault_no | output | 1 | Fault flag, active low |
| state_o | output | 3 | Sequencer state code |

## Verification
The hardest case to reach is the end of the retry wait. Hundreds of cycles must pass with the gate off, and the exact edge where the wait ends and SOFT begins must be seen. The same must also be seen for a wait that was cut short by an enable release. The stimulus uses a small timeout and holds the limit flag high through the wait, so each retry runs straight into a new timeout. It also drops enable partway into a wait and then checks that the next wait lasts the full 64·T cycles. A reference model in the bench is compared on every clock, so an off-by-one in either counter shows up at the boundary cycle.

// File: rtl/hs_seq_pkg.sv
`timescale 1ns/1ps
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SOFT   = 3'd1,
    ST_ON     = 3'd2,
    ST_TIMING = 3'd3,
    ST_LATCH  = 3'd4,
    ST_RWAIT  = 3'd5
  } hs_state_e;
endpackage

// File: rtl/hs_oc_timer.sv
`timescale 1ns/1ps
module hs_oc_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] tout_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;
  logic [TW:0]   eff;

  assign eff      = (tout_i == '0) ? (TW+1)'(1) : {1'b0, tout_i};
  assign cnt_inc  = {1'b0, cnt_q} + (TW+1)'(1);
  assign expire_o = run_i && (cnt_inc >= eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_inc[TW-1:0];
  end

  // R4
  cnt_below_tout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < eff);
  // R4
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/hs_retry_wait.sv
`timescale 1ns/1ps
module hs_retry_wait #(
  parameter int TW      = 16,
  parameter int RETRY_N = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] tout_i,
  output logic          done_o
);
  localparam int RW = (RETRY_N > 1) ? $clog2(RETRY_N) : 1;

  logic [TW-1:0] icnt_q;
  logic [RW-1:0] rcnt_q;
  logic [TW:0]   eff;
  logic          last_int;

  assign eff      = (tout_i == '0) ? (TW+1)'(1) : {1'b0, tout_i};
  assign last_int = ({1'b0, icnt_q} + (TW+1)'(1)) >= eff;
  assign done_o   = run_i && last_int && (rcnt_q == RW'(RETRY_N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      rcnt_q <= '0;
    end else if (!run_i || done_o) begin
      icnt_q <= '0;
      rcnt_q <= '0;
    end else if (last_int) begin
      icnt_q <= '0;
      rcnt_q <= rcnt_q + RW'(1);
    end else begin
      icnt_q <= icnt_q + TW'(1);
    end
  end

  // R7
  interval_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && (rcnt_q != $past(rcnt_q)) |-> icnt_q == '0);
  // R11
  wait_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> rcnt_q == '0 && icnt_q == '0);
endmodule

// File: rtl/hs_fault_seq.sv
`timescale 1ns/1ps
module hs_fault_seq
  import hs_seq_pkg::*;
#(
  parameter int TW      = 16,
  parameter int RETRY_N = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ok_i,
  input  logic          en_ni,
  input  logic          lim_i,
  input  logic          sev_oc_i,
  input  logic          retry_i,
  input  logic          ss_done_i,
  input  logic [TW-1:0] tout_i,
  output logic          gate_en_o,
  output logic          gate_pd_o,
  output logic          ss_rst_o,
  output logic          fault_no,
  output logic [2:0]    state_o
);
  hs_state_e state_q, state_d;
  logic      act, live, tmr_run, tmr_exp, rw_run, rw_done;
  logic      sev_q, pd_d;
  logic      gate_en_q, gate_pd_q, ss_rst_q, fault_n_q;

  assign act     = por_ok_i && !en_ni;
  assign live    = (state_q == ST_SOFT) || (state_q == ST_ON) || (state_q == ST_TIMING);
  assign tmr_run = act && live && lim_i;
  assign rw_run  = act && (state_q == ST_RWAIT);

  hs_oc_timer #(.TW(TW)) u_oc_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (tmr_run),
    .tout_i  (tout_i),
    .expire_o(tmr_exp)
  );

  hs_retry_wait #(.TW(TW), .RETRY_N(RETRY_N)) u_retry_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (rw_run),
    .tout_i(tout_i),
    .done_o(rw_done)
  );

  always_comb begin
    state_d = state_q;
    pd_d    = 1'b0;
    if (!act) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_SOFT;
        ST_SOFT, ST_ON, ST_TIMING: begin
          if (sev_oc_i && !sev_q) pd_d = 1'b1;
          if (tmr_exp) begin
            pd_d    = 1'b1;
            state_d = retry_i ? ST_RWAIT : ST_LATCH;
          end else if (lim_i) begin
            state_d = ST_TIMING;
          end else if (state_q == ST_TIMING) begin
            state_d = ss_done_i ? ST_ON : ST_SOFT;
          end else if (state_q == ST_SOFT && ss_done_i) begin
            state_d = ST_ON;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        ST_RWAIT: if (rw_done) state_d = ST_SOFT;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      sev_q     <= 1'b0;
      gate_en_q <= 1'b0;
      gate_pd_q <= 1'b0;
      ss_rst_q  <= 1'b1;
      fault_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      sev_q     <= sev_oc_i;
      gate_en_q <= (state_d == ST_SOFT) || (state_d == ST_ON) || (state_d == ST_TIMING);
      gate_pd_q <= pd_d;
      ss_rst_q  <= (state_d == ST_OFF) || (state_d == ST_LATCH) || (state_d == ST_RWAIT);
      fault_n_q <= !((state_d == ST_LATCH) || (state_d == ST_RWAIT));
    end
  end

  assign gate_en_o = gate_en_q;
  assign gate_pd_o = gate_pd_q;
  assign ss_rst_o  = ss_rst_q;
  assign fault_no  = fault_n_q;
  assign state_o   = state_q;

  // R1
  por_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> state_q == ST_OFF && !gate_en_o && ss_rst_o && fault_no);
  // R2
  gate_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> fault_no && !ss_rst_o);
  // R5
  fault_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_no) |-> gate_pd_o && !gate_en_o);
  // R6
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LATCH && act |=> state_q == ST_LATCH && !fault_no);
  // R9
  sev_keep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && live && sev_oc_i && !sev_q && !lim_i |=> gate_pd_o && gate_en_o);
  // R11
  wait_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RWAIT && en_ni |=> state_q == ST_OFF && fault_no);
endmodule

// File: tb/hs_fault_seq_tb.sv
`timescale 1ns/1ps
module hs_fault_seq_tb;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0, en_n = 1'b1, lim = 1'b0, sev = 1'b0, retry = 1'b0, ssd = 1'b0;
  logic [TW-1:0] tout = 16'd8;
  logic gate_en, gate_pd, ss_rst, fault_n;
  logic [2:0] st;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_st = 0, m_run = 0, m_wait = 0;
  bit m_sevq = 0, m_pd = 0;

  always #2 clk = ~clk;

  hs_fault_seq #(.TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .en_ni(en_n), .lim_i(lim),
    .sev_oc_i(sev), .retry_i(retry), .ss_done_i(ssd), .tout_i(tout),
    .gate_en_o(gate_en), .gate_pd_o(gate_pd), .ss_rst_o(ss_rst),
    .fault_no(fault_n), .state_o(st)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_wait = 0; m_sevq = 0; m_pd = 0;
    end else begin
      int eff;
      eff  = (tout == 0) ? 1 : int'(tout);
      m_pd = 0;
      if (!por || en_n) begin
        m_st = 0; m_run = 0; m_wait = 0;
      end else if (m_st == 0) begin
        m_st = 1;
      end else if (m_st >= 1 && m_st <= 3) begin
        if (sev && !m_sevq) m_pd = 1;
        if (lim) begin
          m_run++;
          if (m_run >= eff) begin
            m_pd = 1; m_run = 0; m_wait = 0;
            m_st = retry ? 5 : 4;
          end else m_st = 3;
        end else begin
          m_run = 0;
          if (m_st == 3) m_st = ssd ? 2 : 1;
          else if (m_st == 1 && ssd) m_st = 2;
        end
      end else if (m_st == 5) begin
        m_wait++;
        if (m_wait == 64 * eff) begin m_st = 1; m_wait = 0; end
      end
      m_sevq = sev;
    end
  end

  // every-cycle comparison; R12 covers state codes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_ge, exp_sr, exp_fn;
      exp_ge = (m_st >= 1 && m_st <= 3);
      exp_sr = (m_st == 0 || m_st >= 4);
      exp_fn = !(m_st >= 4);
      checks++;
      if (st != 3'(m_st) || gate_en != exp_ge || gate_pd != m_pd ||
          ss_rst != exp_sr || fault_n != exp_fn) begin
        bad++;
        $display("FAIL %s/R12 t=%0t act st=%0d ge=%0b pd=%0b sr=%0b fn=%0b exp st=%0d ge=%0b pd=%0b sr=%0b fn=%0b",
                 cur_req, $time, st, gate_en, gate_pd, ss_rst, fault_n,
                 m_st, exp_ge, m_pd, exp_sr, exp_fn);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R1";
    chk("R1", st, 0); chk("R1", gate_en, 0); chk("R1", ss_rst, 1); chk("R1", fault_n, 1);
    en_n = 1'b0;
    tick(2);
    chk("R1", st, 0);

    cur_req = "R2";
    por = 1'b1;
    tick(1);
    chk("R2", st, 1); chk("R2", gate_en, 1); chk("R2", ss_rst, 0);

    cur_req = "R4";
    lim = 1'b1; tick(3);
    chk("R4", st, 3);
    lim = 1'b0; tick(1);
    chk("R4", st, 1); chk("R4", fault_n, 1);
    lim = 1'b1; tick(7); lim = 1'b0; tick(1);
    chk("R4", fault_n, 1);

    cur_req = "R3";
    ssd = 1'b1; tick(1);
    chk("R3", st, 2);

    cur_req = "R9";
    sev = 1'b1; tick(1);
    chk("R9", gate_pd, 1); chk("R9", gate_en, 1);
    tick(1);
    chk("R9", gate_pd, 0);
    sev = 1'b0; tick(1);

    cur_req = "R5";
    lim = 1'b1; tick(7);
    chk("R5", fault_n, 1); chk("R5", st, 3);
    tick(1);
    chk("R5", gate_pd, 1); chk("R5", gate_en, 0); chk("R5", ss_rst, 1);
    chk("R5", fault_n, 0); chk("R6", st, 4);
    tick(1);
    chk("R5", gate_pd, 0);

    cur_req = "R6";
    lim = 1'b0; tick(5);
    sev = 1'b1; tick(1);
    chk("R9", gate_pd, 0); chk("R6", st, 4);
    sev = 1'b0; tick(1);
    en_n = 1'b1; tick(1);
    chk("R6", st, 0); chk("R6", fault_n, 1);
    en_n = 1'b0; tick(1);
    chk("R2", st, 1);
    tick(1);

    cur_req = "R7";
    retry = 1'b1; lim = 1'b1; tick(8);
    chk("R7", st, 5); chk("R7", fault_n, 0);
    tick(64 * 8 - 1);
    chk("R7", st, 5); chk("R7", gate_en, 0);
    tick(1);
    chk("R7", st, 1); chk("R7", fault_n, 1);

    cur_req = "R8";
    tick(8);
    chk("R8", st, 5); chk("R8", fault_n, 0);

    cur_req = "R11";
    tick(100);
    en_n = 1'b1; tick(1);
    chk("R11", st, 0); chk("R11", fault_n, 1);
    en_n = 1'b0; tick(1);
    tick(8);
    chk("R11", st, 5);
    tick(64 * 8 - 1);
    chk("R11", st, 5);
    tick(1);
    chk("R11", st, 1);

    cur_req = "R10";
    en_n = 1'b1; lim = 1'b0; retry = 1'b0; tick(1);
    tout = '0; en_n = 1'b0; tick(1);
    chk("R10", st, 1);
    lim = 1'b1; tick(1);
    chk("R10", st, 4); chk("R10", gate_pd, 1);
    en_n = 1'b1; tick(1);
    retry = 1'b1; en_n = 1'b0; tick(1);
    tick(1);
    chk("R10", st, 5);
    tick(63);
    chk("R10", st, 5);
    tick(1);
    chk("R10", st, 1);

    cur_req = "R1";
    por = 1'b0; tick(1);
    chk("R1", st, 0); chk("R1", gate_en, 0); chk("R1", fault_n, 1);
    lim = 1'b0; tick(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule